// File: doc/BRIEF.md
# Received-Stream Pattern Checker with Bit and Error Counters

This block sits on the receive side of a bit error rate test path. Each clock cycle in which the receive gate is low, it takes one bit from the incoming serial stream. It predicts what that bit should have been from the bits received before it. In pseudorandom mode the prediction is the XOR of two earlier bits, picked by the configured length and feedback tap, so the checker locks onto the transmitted sequence from the received data alone. In repetitive mode the prediction is the bit one pattern length earlier, so any stream with the configured period satisfies it.

A hunt/lock synchronizer declares lock after a long enough run of correct predictions. It falls back to hunting when errors become frequent or when software requests a resync. While locked, each mispredicted bit adds one to an error counter. A second counter counts every accepted bit. A rising edge on the load strobe closes the integration period: both running counts move into holding registers and the running counts restart. Two run-length flags report a received stream stuck at all ones or all zeros, which would otherwise pass the pseudorandom check.

Top module: `ber_rx_checker`

## Requirements
- R1: With `mode_prbs`=1, the expected bit is the bit received `len_m1`+1 accepted bits earlier XOR the bit received `tap_sel`+1 accepted bits earlier. Before any bit is accepted, the history holds zeros.
- R2: With `mode_prbs`=0, the expected bit is the bit received `len_m1`+1 accepted bits earlier. A stream with a different period does not hold lock.
- R3: While hunting with `sync_en`=1, `in_sync` rises after the edge of the accepted bit that completes a run of 34+`len_m1`+1 consecutive correct predictions. A wrong prediction restarts the run.
- R4: `rx_all_ones` (`rx_all_zeros`) is high once the last 32 or more accepted bits are all 1 (all 0). It drops on the first accepted bit that differs. The two flags are never high together.
- R5: While `sync_en`=0, the synchronizer holds its state: no lock is acquired and no lock is lost.
- R6: An accepted bit adds one to the running error count only if it is mispredicted while `in_sync` is high.
- R7: While locked, accepted bits are grouped into consecutive 64-bit windows, the first starting at lock. A 6th error inside one window returns the block to hunting. A `resync` pulse forces hunting on the next edge.
- R8: Every accepted bit adds one to the running bit count, whether or not the block is locked.
- R9: On a rising edge of `load_cnt`, the holding registers take the running counts including that cycle's bit, and the running counts restart from zero in the same cycle. Holding `load_cnt` high does not trigger again.
- R10: Both running counts saturate at all ones instead of wrapping.
- R11: A cycle with `rx_dis`=1 changes neither the history, the flags, the counts nor the synchronizer (except through `resync`).
- R12: After reset, `in_sync`, both flags and both holding registers are zero and the history is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 1 | Received serial bit |
| rx_dis | input | 1 | 1 = ignore this cycle |
| mode_prbs | input | 1 | 1 = pseudorandom, 0 = repetitive |
| len_m1 | input | 5 | Pattern length / polynomial exponent minus one |
| tap_sel | input | 5 | Feedback tap minus one (pseudorandom mode) |
| sync_en | input | 1 | Allows the synchronizer to change state |
| resync | input | 1 | Forces hunting |
| load_cnt | input | 1 | Rising edge ends the integration period |
| in_sync | output | 1 | Lock declared |
| rx_all_ones | output | 1 | 32 or more ones in a row |
| rx_all_zeros | output | 1 | 32 or more zeros in a row |
| err_held | output | CNT_W (32) | Latched error count |
| bit_held | output | CNT_W (32) | Latched bit count |

## Verification
Every result is registered once: lock, the flags and the holding registers all reflect a bit, a resync or a load edge from the first rising edge after it was driven. The bench drives on the falling edge and compares all five outputs against its behavioural model on the next falling edge, so each comparison sees exactly one new edge. The directed checks (lock on the exact bit, error doubling on a flipped bit, saturation, gating) insert one idle gated cycle before sampling, and that cycle cannot change any state.

// File: rtl/ber_rx_pkg.sv
// Shared types for the receive pattern checker.
package ber_rx_pkg;
    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } sync_state_e;
endpackage

// File: rtl/ber_ref_predict.sv
// Keeps the history of accepted bits and predicts the current bit from it.
// Assumes len_m1 and tap_sel index inside PAT_W; history is newest-first.
module ber_ref_predict #(
    parameter int PAT_W = 32,
    localparam int LEN_W = $clog2(PAT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             rx_bit,
    input  logic             mode_prbs,
    input  logic [LEN_W-1:0] len_m1,
    input  logic [LEN_W-1:0] tap_sel,
    output logic             mismatch
);
    logic [PAT_W-1:0] hist;
    logic             expected;

    // Prediction: one period back, XOR the feedback tap in pseudorandom mode.
    always_comb begin
        expected = hist[len_m1] ^ (mode_prbs & hist[tap_sel]);
        mismatch = rx_bit ^ expected;
    end

    // Shift each accepted bit into the history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (bit_en) begin
            hist <= {hist[PAT_W-2:0], rx_bit};
        end
    end

    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(hist)); // R11
endmodule

// File: rtl/ber_sync_fsm.sv
// Hunt/lock synchronizer. Declares lock after a run of correct predictions
// and drops it on too many errors in one window or on a resync request.
// Assumes mismatch is valid whenever bit_en is high.
module ber_sync_fsm #(
    parameter int PAT_W      = 32,
    parameter int SYNC_EXTRA = 34,
    parameter int LOSS_WIN   = 64,
    parameter int LOSS_ERRS  = 6,
    localparam int LEN_W = $clog2(PAT_W),
    localparam int RUN_W = $clog2(SYNC_EXTRA + PAT_W + 1),
    localparam int WIN_W = $clog2(LOSS_WIN),
    localparam int ERR_W = $clog2(LOSS_ERRS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             mismatch,
    input  logic             sync_en,
    input  logic             resync,
    input  logic [LEN_W-1:0] len_m1,
    output logic             in_sync
);
    import ber_rx_pkg::*;

    sync_state_e      state;
    logic [RUN_W-1:0] run_cnt;
    logic [RUN_W-1:0] run_need;
    logic [WIN_W-1:0] win_cnt;
    logic [ERR_W-1:0] win_errs;
    logic [ERR_W-1:0] win_errs_nxt;

    // Length of the error-free run needed for lock, and the window error tally.
    always_comb begin
        run_need     = RUN_W'(SYNC_EXTRA) + RUN_W'(len_m1) + RUN_W'(1);
        win_errs_nxt = win_errs + ERR_W'(mismatch);
    end

    // State, run length and loss-window bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || resync) begin
            state    <= ST_HUNT;
            run_cnt  <= '0;
            win_cnt  <= '0;
            win_errs <= '0;
        end else if (bit_en && sync_en) begin
            if (state == ST_HUNT) begin
                if (mismatch) begin
                    run_cnt <= '0;
                end else if (run_cnt + RUN_W'(1) == run_need) begin
                    state    <= ST_LOCK;
                    run_cnt  <= '0;
                    win_cnt  <= '0;
                    win_errs <= '0;
                end else begin
                    run_cnt <= run_cnt + RUN_W'(1);
                end
            end else begin
                if (win_errs_nxt == ERR_W'(LOSS_ERRS)) begin
                    state    <= ST_HUNT;
                    win_cnt  <= '0;
                    win_errs <= '0;
                end else if (win_cnt == WIN_W'(LOSS_WIN - 1)) begin
                    win_cnt  <= '0;
                    win_errs <= '0;
                end else begin
                    win_cnt  <= win_cnt + WIN_W'(1);
                    win_errs <= win_errs_nxt;
                end
            end
        end
    end

    assign in_sync = (state == ST_LOCK);

    AST_LOCK_ON_GOOD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> $past(bit_en && !mismatch && sync_en && !resync)); // R3
    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        win_errs < ERR_W'(LOSS_ERRS)); // R7
    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_en && !resync) |=> $stable(in_sync)); // R5
endmodule

// File: rtl/ber_run_detect.sv
// Flags a received stream stuck at one level for RUN_LEN accepted bits.
// Assumes the first accepted bit after reset starts a run of one.
module ber_run_detect #(
    parameter int RUN_LEN = 32,
    localparam int SC_W = $clog2(RUN_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    output logic all_ones,
    output logic all_zeros
);
    logic [SC_W-1:0] same_cnt;
    logic            last_bit;

    // Track the level of the last bit and how long it has repeated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            same_cnt <= '0;
            last_bit <= 1'b0;
        end else if (bit_en) begin
            last_bit <= rx_bit;
            if (rx_bit != last_bit) begin
                same_cnt <= SC_W'(1);
            end else if (same_cnt != SC_W'(RUN_LEN)) begin
                same_cnt <= same_cnt + SC_W'(1);
            end
        end
    end

    // Flags from the run length and its level.
    always_comb begin
        all_ones  = (same_cnt == SC_W'(RUN_LEN)) &&  last_bit;
        all_zeros = (same_cnt == SC_W'(RUN_LEN)) && !last_bit;
    end

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(all_ones && all_zeros)); // R4
    AST_FLAG_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (all_ones && bit_en && !rx_bit) |=> !all_ones); // R4
endmodule

// File: rtl/ber_counters.sv
// Running error and bit counters with holding registers loaded on a rising
// edge of the load strobe. Assumes err_hit is only meaningful with bit_en.
module ber_counters #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             mismatch,
    input  logic             in_sync,
    input  logic             load_req,
    output logic [CNT_W-1:0] err_held,
    output logic [CNT_W-1:0] bit_held
);
    logic [CNT_W-1:0] err_run;
    logic [CNT_W-1:0] bit_run;
    logic [CNT_W-1:0] err_nxt;
    logic [CNT_W-1:0] bit_nxt;
    logic             load_prev;
    logic             ld_edge;
    logic             err_inc;

    // Saturating next counts and load edge detection.
    always_comb begin
        err_inc = bit_en && mismatch && in_sync;
        err_nxt = (err_inc && (err_run != '1)) ? err_run + CNT_W'(1) : err_run;
        bit_nxt = (bit_en  && (bit_run != '1)) ? bit_run + CNT_W'(1) : bit_run;
        ld_edge = load_req && !load_prev;
    end

    // Count, or hand the counts over and restart on a load edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_run   <= '0;
            bit_run   <= '0;
            err_held  <= '0;
            bit_held  <= '0;
            load_prev <= 1'b0;
        end else begin
            load_prev <= load_req;
            if (ld_edge) begin
                err_held <= err_nxt;
                bit_held <= bit_nxt;
                err_run  <= '0;
                bit_run  <= '0;
            end else begin
                err_run <= err_nxt;
                bit_run <= bit_nxt;
            end
        end
    end

    AST_ERR_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (err_run != $past(err_run) && !$past(ld_edge)) |-> $past(in_sync && bit_en)); // R6
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ld_edge) |-> (bit_run >= $past(bit_run))); // R10
    AST_RESTART_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_edge |=> (bit_run == '0 && err_run == '0)); // R9
endmodule

// File: rtl/ber_rx_checker.sv
// Top of the receive pattern checker: prediction, synchronizer, stuck-level
// flags and integration counters. Assumes the configuration inputs are
// static while a measurement runs.
module ber_rx_checker #(
    parameter int PAT_W      = 32,
    parameter int CNT_W      = 32,
    parameter int SYNC_EXTRA = 34,
    parameter int LOSS_WIN   = 64,
    parameter int LOSS_ERRS  = 6,
    parameter int RUN_LEN    = 32,
    localparam int LEN_W = $clog2(PAT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_data,
    input  logic             rx_dis,
    input  logic             mode_prbs,
    input  logic [LEN_W-1:0] len_m1,
    input  logic [LEN_W-1:0] tap_sel,
    input  logic             sync_en,
    input  logic             resync,
    input  logic             load_cnt,
    output logic             in_sync,
    output logic             rx_all_ones,
    output logic             rx_all_zeros,
    output logic [CNT_W-1:0] err_held,
    output logic [CNT_W-1:0] bit_held
);
    logic bit_en;
    logic mismatch;

    // A bit is accepted only when the receive gate is open.
    assign bit_en = !rx_dis;

    ber_ref_predict #(.PAT_W(PAT_W)) u_pred (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .rx_bit    (rx_data),
        .mode_prbs (mode_prbs),
        .len_m1    (len_m1),
        .tap_sel   (tap_sel),
        .mismatch  (mismatch)
    );

    ber_sync_fsm #(
        .PAT_W      (PAT_W),
        .SYNC_EXTRA (SYNC_EXTRA),
        .LOSS_WIN   (LOSS_WIN),
        .LOSS_ERRS  (LOSS_ERRS)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .mismatch (mismatch),
        .sync_en  (sync_en),
        .resync   (resync),
        .len_m1   (len_m1),
        .in_sync  (in_sync)
    );

    ber_run_detect #(.RUN_LEN(RUN_LEN)) u_runs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .rx_bit    (rx_data),
        .all_ones  (rx_all_ones),
        .all_zeros (rx_all_zeros)
    );

    ber_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .mismatch (mismatch),
        .in_sync  (in_sync),
        .load_req (load_cnt),
        .err_held (err_held),
        .bit_held (bit_held)
    );

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(load_cnt) |=> $stable(bit_held)); // R9
endmodule

// File: tb/tb_ber_rx_checker.sv
module tb_ber_rx_checker;
    localparam int CW = 10;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_data = 1'b0, rx_dis = 1'b1, mode_prbs = 1'b1;
    logic sync_en = 1'b1, resync = 1'b0, load_cnt = 1'b0;
    logic [4:0] len_m1 = 5'd6, tap_sel = 5'd5;
    logic in_sync, rx_all_ones, rx_all_zeros;
    logic [CW-1:0] err_held, bit_held;

    int n_checks = 0, n_fail = 0, cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ber_rx_checker #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_dis(rx_dis),
        .mode_prbs(mode_prbs), .len_m1(len_m1), .tap_sel(tap_sel),
        .sync_en(sync_en), .resync(resync), .load_cnt(load_cnt),
        .in_sync(in_sync), .rx_all_ones(rx_all_ones), .rx_all_zeros(rx_all_zeros),
        .err_held(err_held), .bit_held(bit_held)
    );

    // Behavioural reference model.
    bit mq[$];
    bit m_sync, m_last, m_ldp, m_mism, m_edge, m_exp;
    int m_run, m_win, m_ew, m_b, m_e, m_hb, m_he, m_same;

    function automatic int sat(int v, bit inc);
        return (inc && v < CMAX) ? v + 1 : v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq = {};
            for (int i = 0; i < 32; i++) mq.push_back(1'b0);
            m_sync = 0; m_last = 0; m_ldp = 0;
            m_run = 0; m_win = 0; m_ew = 0; m_b = 0; m_e = 0;
            m_hb = 0; m_he = 0; m_same = 0;
        end else begin
            m_edge = load_cnt && !m_ldp;
            m_ldp = load_cnt;
            m_mism = 0;
            if (!rx_dis) begin
                m_exp = mq[len_m1];
                if (mode_prbs) m_exp = m_exp ^ mq[tap_sel];
                m_mism = (rx_data != m_exp);
            end
            if (m_edge) begin
                m_hb = sat(m_b, !rx_dis); m_he = sat(m_e, !rx_dis && m_mism && m_sync);
                m_b = 0; m_e = 0;
            end else begin
                m_b = sat(m_b, !rx_dis); m_e = sat(m_e, !rx_dis && m_mism && m_sync);
            end
            if (resync) begin
                m_sync = 0; m_run = 0; m_win = 0; m_ew = 0;
            end else if (!rx_dis && sync_en) begin
                if (!m_sync) begin
                    if (m_mism) m_run = 0;
                    else begin
                        m_run++;
                        if (m_run == 34 + len_m1 + 1) begin
                            m_sync = 1; m_run = 0; m_win = 0; m_ew = 0;
                        end
                    end
                end else begin
                    m_ew += m_mism;
                    m_win++;
                    if (m_ew == 6) begin
                        m_sync = 0; m_win = 0; m_ew = 0;
                    end else if (m_win == 64) begin
                        m_win = 0; m_ew = 0;
                    end
                end
            end
            if (!rx_dis) begin
                if (rx_data == m_last) m_same++; else m_same = 1;
                m_last = rx_data;
                mq.push_front(rx_data);
                void'(mq.pop_back());
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_model();
        check("R3", "in_sync vs model", in_sync, m_sync);
        check("R4", "all_ones vs model", rx_all_ones, m_same >= 32 && m_last);
        check("R4", "all_zeros vs model", rx_all_zeros, m_same >= 32 && !m_last);
        check("R6", "err_held vs model", err_held, m_he);
        check("R8", "bit_held vs model", bit_held, m_hb);
    endtask

    // One cycle: compare previous results, then drive this cycle's inputs.
    task automatic step(bit b, bit dis, bit ld, bit rs);
        @(negedge clk);
        if (rst_n) compare_model();
        rx_data = b; rx_dis = dis; load_cnt = ld; resync = rs;
    endtask

    task automatic idle();
        step(1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    logic [6:0] p7 = 7'h5B;
    function automatic bit prbs_next();
        bit o;
        o = p7[6] ^ p7[5];
        p7 = {p7[5:0], o};
        return o;
    endfunction

    task automatic send_prbs(int cnt, bit inv, int flip_at);
        for (int i = 0; i < cnt; i++) begin
            bit b;
            b = prbs_next() ^ inv ^ (i == flip_at);
            step(b, 1'b0, 1'b0, 1'b0);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12", "in_sync in reset", in_sync, 0);
        check("R12", "err_held in reset", err_held, 0);
        check("R12", "bit_held in reset", bit_held, 0);
        check("R12", "flags in reset", rx_all_ones | rx_all_zeros, 0);
        rst_n = 1'b1;

        // Pseudorandom x^7+x^6+1 lock.
        send_prbs(150, 0, -1);
        idle();
        check("R1", "prbs lock", in_sync, 1);

        // Integration with one flipped bit: three errors by prediction.
        step(prbs_next(), 1'b0, 1'b1, 1'b0);
        send_prbs(50, 0, 20);
        step(prbs_next(), 1'b0, 1'b1, 1'b0);
        idle();
        check("R9", "held bits", bit_held, 51);
        check("R6", "held errors", err_held, 3);

        // Gated cycles change nothing.
        send_prbs(10, 0, -1);
        for (int i = 0; i < 20; i++) step(i[0] ^ i[2], 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b1, 1'b0);
        idle();
        check("R11", "bits across gate", bit_held, 10);
        check("R11", "errors across gate", err_held, 0);
        check("R11", "lock across gate", in_sync, 1);

        // Level-held load fires once.
        for (int i = 0; i < 5; i++) step(prbs_next(), 1'b0, 1'b1, 1'b0);
        idle();
        step(1'b0, 1'b1, 1'b1, 1'b0);
        idle();
        check("R9", "no retrigger", bit_held, 4);

        // Loss of lock on an inverted stream.
        send_prbs(12, 1, -1);
        idle();
        check("R7", "lost after errors", in_sync, 0);
        send_prbs(150, 0, -1);
        idle();
        check("R7", "relock", in_sync, 1);
        step(1'b0, 1'b1, 1'b0, 1'b1);
        idle();
        check("R7", "resync drops lock", in_sync, 0);

        // Synchronizer disabled.
        sync_en = 1'b0;
        send_prbs(150, 0, -1);
        idle();
        check("R5", "no lock while off", in_sync, 0);
        sync_en = 1'b1;
        send_prbs(150, 0, -1);
        idle();
        sync_en = 1'b0;
        send_prbs(12, 1, -1);
        idle();
        check("R5", "no loss while off", in_sync, 1);
        sync_en = 1'b1;

        // Exact lock point: 34+7 correct bits.
        send_prbs(20, 0, -1);
        step(1'b0, 1'b1, 1'b0, 1'b1);
        send_prbs(40, 0, -1);
        idle();
        check("R3", "not yet locked", in_sync, 0);
        send_prbs(1, 0, -1);
        idle();
        check("R3", "locked on last bit", in_sync, 1);

        // Repetitive mode, 12-bit period.
        mode_prbs = 1'b0; len_m1 = 5'd11;
        step(1'b0, 1'b1, 1'b0, 1'b1);
        for (int r = 0; r < 10; r++)
            for (int i = 11; i >= 0; i--) step(12'hA5C >> i, 1'b0, 1'b0, 1'b0);
        idle();
        check("R2", "repetitive lock", in_sync, 1);
        for (int r = 0; r < 10; r++)
            for (int i = 12; i >= 0; i--) step(13'h1A5C >> i, 1'b0, 1'b0, 1'b0);
        idle();
        check("R2", "wrong period drops", in_sync, 0);

        // Stuck-level flags.
        step(1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 31; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
        idle();
        check("R4", "31 ones", rx_all_ones, 0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        idle();
        check("R4", "32 ones", rx_all_ones, 1);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        idle();
        check("R4", "ones cleared", rx_all_ones, 0);
        for (int i = 0; i < 31; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
        idle();
        check("R4", "32 zeros", rx_all_zeros, 1);

        // Saturation.
        step(1'b0, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 1030; i++) step(i[1], 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b1, 1'b0);
        idle();
        check("R10", "bit count saturates", bit_held, CMAX);

        idle();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule